// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Scheduler

This block keeps an asynchronous DRAM alive. Leaving reset, it counts out the power-up pause the memory needs. It then runs a short wake-up burst of RAS cycles and only after that reports the memory as usable. From then on it owes the memory one refresh every fixed interval. The interval is set so that the whole row space is covered inside the retention window: 4096 refreshes per 64 ms, about 15.6 µs apart.

The scheduler shares the DRAM pins with a host access controller. When it has work, it raises a request and waits for a grant. While granted, it drives the strobes itself. The controller holds the grant until the request drops. The request drops only after both strobes are back high and the precharge time has elapsed.

By default each refresh uses the CAS-before-RAS order, so the address pins are don't-care. A parameter selects the row-address variant instead: a local row counter drives the address and CAS stays high. A refresh that cannot be granted is remembered as owed. If the owed count is already at its limit when one more refresh falls due, the block raises an overdue flag, withdraws the ready indication and runs the wake-up burst again.

Top module: `dram_refresh_sched`

## Requirements
- R1: While `rst_n` is low, `ras_n`, `cas_n`, `we_n` and `oe_n` are 1, and `ref_req`, `mem_ready` and `overdue` are 0.
- R2: After reset is released, `ref_req` stays 0 for the first PAUSE_CYC clock cycles. It rises in cycle PAUSE_CYC+1.
- R3: After the pause, exactly INIT_CNT RAS cycles (falling edges of `ras_n`) are issued before `mem_ready` becomes 1, and `overdue` stays 0.
- R4: While `mem_ready` is 1 and grants are immediate, successive falling edges of `ras_n` are exactly REF_INTERVAL cycles apart.
- R5: `ref_req` stays 1 until it is granted and the cycle completes. `ras_n` and `cas_n` go low only while `ref_req` is 1, and never before `ref_gnt` has been given.
- R6: In CAS-before-RAS mode, `cas_n` is low for at least T_CSR cycles before `ras_n` falls. `ras_n` is then low for exactly T_RAS cycles, and `cas_n` returns high together with `ras_n`.
- R7: Before `ref_req` drops, both `ras_n` and `cas_n` have been high for exactly T_RP cycles of the granted cycle.
- R8: `we_n` and `oe_n` are always 1; the block never moves data.
- R9: Refreshes that fell due while the grant was withheld are served back to back once it is given. The gap between falling edges of `ras_n` is T_CSR+T_RAS+T_RP+2 cycles, and `mem_ready` stays 1.
- R10: When a refresh falls due while BACKLOG_MAX are already owed, `overdue` goes to 1 and `mem_ready` to 0. Then exactly INIT_CNT RAS cycles are issued, after which `mem_ready` returns to 1 and `overdue` to 0. `mem_ready` and `overdue` are never 1 together.
- R11: In row-address mode, `cas_n` stays 1. `addr` is stable while `ras_n` is low, and it presents 0, 1, 2, … at successive RAS cycles, wrapping modulo 2^ROW_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_req | output | 1 | Request for ownership of the DRAM pins |
| ref_gnt | input | 1 | Grant from the access controller; held until `ref_req` drops |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, held inactive (1) |
| oe_n | output | 1 | Output enable, held inactive (1) |
| addr | output | ROW_W | Row address in row-address mode, 0 otherwise |
| mem_ready | output | 1 | Memory initialised and refresh on schedule |
| overdue | output | 1 | Refresh deadline missed; wake-up burst in progress |

## Verification
The hardest state to reach is the missed deadline. It needs the owed count to sit at its limit exactly when one more refresh falls due, with no cycle in flight. From the ports, that only happens if the controller starves the block for several intervals. The bench gets there by gating its grant model: it stops granting only after any granted cycle has finished, then waits past BACKLOG_MAX intervals. A shorter starvation window, which must not trigger the flag, is used first to check the back-to-back catch-up. After the grant returns, the bench counts RAS falls until `mem_ready` comes back, to check the re-run wake-up burst.

// File: rtl/dram_refresh_pkg.sv
// Shared types for the DRAM refresh scheduler.
// Assumes: included first in compile order.
package dram_refresh_pkg;

    // Scheduler life phases.
    typedef enum logic [1:0] {
        PH_PAUSE,
        PH_WAKE,
        PH_RUN
    } phase_e;

    // Strobe sequencer states.
    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_WAIT,
        SQ_SETUP,
        SQ_ACTIVE,
        SQ_PRECH
    } seq_e;

endpackage

// File: rtl/drs_interval_timer.sv
// Refresh interval timer and owed-refresh counter.
// Counts REF_INTERVAL cycles while enabled and adds one owed refresh per
// period; each served refresh removes one. When a period ends with
// BACKLOG_MAX already owed and none served, it pulses `late`.
// Assumes: REF_INTERVAL >= 2, BACKLOG_MAX >= 1; disabling clears all state.
module drs_interval_timer #(
    parameter int REF_INTERVAL = 1562,
    parameter int BACKLOG_MAX  = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic served,
    output logic owed_any,
    output logic late
);
    localparam int CW = $clog2(REF_INTERVAL + 1);
    localparam int OW = $clog2(BACKLOG_MAX + 2);

    logic [CW-1:0] cnt_q;
    logic [OW-1:0] owed_q;
    logic          tick;

    assign tick     = enable && (cnt_q == CW'(REF_INTERVAL - 1));
    assign late     = tick && !served && (owed_q == OW'(BACKLOG_MAX));
    assign owed_any = (owed_q != '0);

    // Period counter: free-runs while enabled, restarts on wrap.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable || tick) cnt_q <= '0;
        else                           cnt_q <= cnt_q + 1'b1;
    end

    // Owed refreshes: up on tick, down on service, cleared on deadline miss.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable || late) begin
            owed_q <= '0;
        end else begin
            unique case ({tick, served})
                2'b10:   owed_q <= owed_q + 1'b1;
                2'b01:   owed_q <= owed_q - 1'b1;
                default: owed_q <= owed_q;
            endcase
        end
    end
endmodule

// File: rtl/drs_strobe_seq.sv
// Strobe sequencer: for each unit of work it requests the pins, waits for
// grant, then runs setup, RAS-active and precharge phases of fixed length
// and pulses `done` on the last precharge cycle, dropping the request next.
// CAS-before-RAS order unless RAS_ONLY is set, in which case CAS stays high
// and the setup phase is address setup.
// Assumes: grant is held until the request drops; all timings >= 1.
module drs_strobe_seq
    import dram_refresh_pkg::*;
#(
    parameter int T_CSR    = 1,
    parameter int T_RAS    = 5,
    parameter int T_RP     = 3,
    parameter bit RAS_ONLY = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic want,
    input  logic gnt,
    output logic req,
    output logic ras_n,
    output logic cas_n,
    output logic done
);
    localparam int TMAX = (T_CSR > T_RAS) ? ((T_CSR > T_RP) ? T_CSR : T_RP)
                                          : ((T_RAS > T_RP) ? T_RAS : T_RP);
    localparam int TW   = $clog2(TMAX + 1);

    seq_e          st_q;
    logic [TW-1:0] tcnt_q;

    // Phase sequencing with per-phase cycle counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= SQ_IDLE;
            tcnt_q <= '0;
        end else begin
            unique case (st_q)
                SQ_IDLE: begin
                    tcnt_q <= '0;
                    if (want) st_q <= SQ_WAIT;
                end
                SQ_WAIT: begin
                    tcnt_q <= '0;
                    if (gnt) st_q <= SQ_SETUP;
                end
                SQ_SETUP: begin
                    if (tcnt_q == TW'(T_CSR - 1)) begin
                        st_q   <= SQ_ACTIVE;
                        tcnt_q <= '0;
                    end else begin
                        tcnt_q <= tcnt_q + 1'b1;
                    end
                end
                SQ_ACTIVE: begin
                    if (tcnt_q == TW'(T_RAS - 1)) begin
                        st_q   <= SQ_PRECH;
                        tcnt_q <= '0;
                    end else begin
                        tcnt_q <= tcnt_q + 1'b1;
                    end
                end
                SQ_PRECH: begin
                    if (tcnt_q == TW'(T_RP - 1)) begin
                        st_q   <= SQ_IDLE;
                        tcnt_q <= '0;
                    end else begin
                        tcnt_q <= tcnt_q + 1'b1;
                    end
                end
                default: begin
                    st_q   <= SQ_IDLE;
                    tcnt_q <= '0;
                end
            endcase
        end
    end

    assign req   = (st_q != SQ_IDLE);
    assign ras_n = (st_q != SQ_ACTIVE);
    assign done  = (st_q == SQ_PRECH) && (tcnt_q == TW'(T_RP - 1));

    // Column strobe variant chosen by refresh mode.
    generate
        if (RAS_ONLY) begin : g_cas_idle
            assign cas_n = 1'b1;
        end else begin : g_cas_cbr
            assign cas_n = !((st_q == SQ_SETUP) || (st_q == SQ_ACTIVE));
        end
    endgenerate
endmodule

// File: rtl/drs_row_counter.sv
// Row pointer for row-address refresh: advances once per completed cycle
// and wraps at 2^ROW_W.
// Assumes: `adv` is a one-cycle pulse per finished RAS cycle.
module drs_row_counter #(
    parameter int ROW_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    output logic [ROW_W-1:0] row
);
    // Wrapping row pointer.
    always_ff @(posedge clk) begin
        if (!rst_n)   row <= '0;
        else if (adv) row <= row + 1'b1;
    end
endmodule

// File: rtl/dram_refresh_sched.sv
// DRAM refresh and power-up scheduler (top).
// Phases: power-up pause, wake-up burst of INIT_CNT RAS cycles, then
// periodic refresh. A missed deadline returns to the wake-up phase.
// Assumes: the access controller holds ref_gnt until ref_req drops;
// timing parameters are in clock cycles and all >= 1.
module dram_refresh_sched
    import dram_refresh_pkg::*;
#(
    parameter int PAUSE_CYC    = 20000,
    parameter int INIT_CNT     = 8,
    parameter int REF_INTERVAL = 1562,
    parameter int BACKLOG_MAX  = 8,
    parameter int T_CSR        = 1,
    parameter int T_RAS        = 5,
    parameter int T_RP         = 3,
    parameter int ROW_W        = 12,
    parameter bit RAS_ONLY     = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic             ref_req,
    input  logic             ref_gnt,
    output logic             ras_n,
    output logic             cas_n,
    output logic             we_n,
    output logic             oe_n,
    output logic [ROW_W-1:0] addr,
    output logic             mem_ready,
    output logic             overdue
);
    localparam int PW = $clog2(PAUSE_CYC + 1);
    localparam int IW = $clog2(INIT_CNT + 1);

    phase_e        phase_q;
    logic [PW-1:0] pause_q;
    logic [IW-1:0] init_left_q;
    logic          overdue_q;
    logic          done, want, owed_any, late, running, wake_end;

    assign running  = (phase_q == PH_RUN);
    assign wake_end = (phase_q == PH_WAKE) && done && (init_left_q == IW'(1));
    assign want     = ((phase_q == PH_WAKE) && (init_left_q != '0))
                   || (running && owed_any);

    // Phase control: pause -> wake-up -> run, run -> wake-up on late.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_PAUSE;
        end else begin
            unique case (phase_q)
                PH_PAUSE: if (pause_q == PW'(PAUSE_CYC - 1)) phase_q <= PH_WAKE;
                PH_WAKE:  if (wake_end) phase_q <= PH_RUN;
                PH_RUN:   if (late) phase_q <= PH_WAKE;
                default:  phase_q <= PH_PAUSE;
            endcase
        end
    end

    // Power-up pause counter.
    always_ff @(posedge clk) begin
        if (!rst_n)                    pause_q <= '0;
        else if (phase_q == PH_PAUSE)  pause_q <= pause_q + 1'b1;
    end

    // Remaining wake-up cycles; reloaded when a deadline is missed.
    always_ff @(posedge clk) begin
        if (!rst_n)                                init_left_q <= IW'(INIT_CNT);
        else if (running && late)                  init_left_q <= IW'(INIT_CNT);
        else if ((phase_q == PH_WAKE) && done)     init_left_q <= init_left_q - 1'b1;
    end

    // Overdue flag: set on missed deadline, cleared when wake-up completes.
    always_ff @(posedge clk) begin
        if (!rst_n)          overdue_q <= 1'b0;
        else if (late)       overdue_q <= 1'b1;
        else if (wake_end)   overdue_q <= 1'b0;
    end

    drs_interval_timer #(
        .REF_INTERVAL(REF_INTERVAL),
        .BACKLOG_MAX (BACKLOG_MAX)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (running),
        .served  (running && done),
        .owed_any(owed_any),
        .late    (late)
    );

    drs_strobe_seq #(
        .T_CSR   (T_CSR),
        .T_RAS   (T_RAS),
        .T_RP    (T_RP),
        .RAS_ONLY(RAS_ONLY)
    ) u_seq (
        .clk  (clk),
        .rst_n(rst_n),
        .want (want),
        .gnt  (ref_gnt),
        .req  (ref_req),
        .ras_n(ras_n),
        .cas_n(cas_n),
        .done (done)
    );

    // Address source chosen by refresh mode.
    generate
        if (RAS_ONLY) begin : g_row_addr
            drs_row_counter #(.ROW_W(ROW_W)) u_rows (
                .clk  (clk),
                .rst_n(rst_n),
                .adv  (done),
                .row  (addr)
            );
        end else begin : g_no_addr
            assign addr = '0;
        end
    endgenerate

    assign we_n      = 1'b1;
    assign oe_n      = 1'b1;
    assign mem_ready = running;
    assign overdue   = overdue_q;
endmodule

// File: rtl/dram_refresh_sched_chk.sv
// Property checker for dram_refresh_sched, attached by bind.
// Assumes: observes top-level ports only.
module dram_refresh_sched_chk #(
    parameter int ROW_W    = 12,
    parameter bit RAS_ONLY = 1'b0
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ref_req,
    input logic             ref_gnt,
    input logic             ras_n,
    input logic             cas_n,
    input logic [ROW_W-1:0] addr,
    input logic             mem_ready,
    input logic             overdue
);
    p_ras_needs_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !ras_n |-> ref_req);

    p_cas_needs_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !cas_n |-> ref_req);

    p_req_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_req && !ref_gnt) |=> ref_req);

    p_prech_before_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ref_req) |-> (ras_n && cas_n && $past(ras_n) && $past(cas_n)));

    p_ready_excl_overdue_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_ready |-> !overdue);

    p_addr_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!ras_n && !$past(ras_n)) |-> $stable(addr));

    generate
        if (!RAS_ONLY) begin : g_cbr_props
            p_cas_leads_ras_r6: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(ras_n) |-> (!cas_n && ($past(cas_n) == 1'b0)));
        end
    endgenerate
endmodule

bind dram_refresh_sched dram_refresh_sched_chk #(
    .ROW_W   (ROW_W),
    .RAS_ONLY(RAS_ONLY)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ref_req  (ref_req),
    .ref_gnt  (ref_gnt),
    .ras_n    (ras_n),
    .cas_n    (cas_n),
    .addr     (addr),
    .mem_ready(mem_ready),
    .overdue  (overdue)
);

// File: tb/dram_refresh_sched_tb.sv
// Directed bench: one CAS-before-RAS instance (u_dut) with a gated grant
// model, one row-address instance (u_dut_ro) always granted.
module dram_refresh_sched_tb;
    localparam int PAUSE = 50;
    localparam int INIT  = 8;
    localparam int INTV  = 40;
    localparam int BLOG  = 3;
    localparam int TCSR  = 1;
    localparam int TRAS  = 4;
    localparam int TRP   = 2;
    localparam int RW    = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic grant_en = 1'b1;
    logic ref_gnt = 1'b0, ro_gnt = 1'b0;
    logic ref_req, ras_n, cas_n, we_n, oe_n, mem_ready, overdue;
    logic ro_req, ro_ras_n, ro_cas_n, ro_we_n, ro_oe_n, ro_ready, ro_overdue;
    logic [RW-1:0] addr, ro_addr;

    int n_chk = 0, n_fail = 0;

    always #5 clk = ~clk;

    dram_refresh_sched #(.PAUSE_CYC(PAUSE), .INIT_CNT(INIT), .REF_INTERVAL(INTV),
        .BACKLOG_MAX(BLOG), .T_CSR(TCSR), .T_RAS(TRAS), .T_RP(TRP),
        .ROW_W(RW), .RAS_ONLY(1'b0)) u_dut (
        .clk(clk), .rst_n(rst_n), .ref_req(ref_req), .ref_gnt(ref_gnt),
        .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .oe_n(oe_n), .addr(addr),
        .mem_ready(mem_ready), .overdue(overdue));

    dram_refresh_sched #(.PAUSE_CYC(PAUSE), .INIT_CNT(INIT), .REF_INTERVAL(INTV),
        .BACKLOG_MAX(BLOG), .T_CSR(TCSR), .T_RAS(TRAS), .T_RP(TRP),
        .ROW_W(RW), .RAS_ONLY(1'b1)) u_dut_ro (
        .clk(clk), .rst_n(rst_n), .ref_req(ro_req), .ref_gnt(ro_gnt),
        .ras_n(ro_ras_n), .cas_n(ro_cas_n), .we_n(ro_we_n), .oe_n(ro_oe_n),
        .addr(ro_addr), .mem_ready(ro_ready), .overdue(ro_overdue));

    // Grant models: once given, held until the request drops.
    always @(negedge clk) begin
        ref_gnt <= ref_req && (ref_gnt || grant_en);
        ro_gnt  <= ro_req;
    end

    // Port monitor for both instances.
    int cyc = 0, falls = 0, last_fall = 0, last_gap = 0;
    int cas_lead = 0, ras_len = 0, bh = 0;
    int order_err = 0, width_err = 0, prech_err = 0, weoe_err = 0, nreq_err = 0;
    logic prev_ras = 1'b1, prev_req = 1'b0;
    int ro_falls = 0, ro_addr_err = 0, ro_cas_err = 0;
    logic [RW-1:0] ro_exp = '0;
    logic ro_prev_ras = 1'b1;

    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            if (we_n !== 1'b1 || oe_n !== 1'b1 || ro_we_n !== 1'b1 || ro_oe_n !== 1'b1)
                weoe_err++;
            if ((!ras_n || !cas_n) && !ref_req) nreq_err++;
            if (prev_ras && !ras_n) begin
                falls++;
                last_gap  = cyc - last_fall;
                last_fall = cyc;
                if (cas_lead < TCSR) order_err++;
                ras_len = 1;
            end else if (!ras_n) begin
                ras_len++;
            end
            if (!prev_ras && ras_n) begin
                if (ras_len != TRAS) width_err++;
                if (!cas_n) order_err++;
            end
            if (!cas_n && ras_n) cas_lead++;
            else if (cas_n) cas_lead = 0;
            if (prev_req && !ref_req) begin
                if (bh != TRP) prech_err++;
                bh = 0;
            end else if (ras_n && cas_n && ref_req) bh++;
            else if (!ras_n || !cas_n) bh = 0;
            prev_ras = ras_n;
            prev_req = ref_req;
            if (ro_prev_ras && !ro_ras_n) begin
                if (ro_addr !== ro_exp) ro_addr_err++;
                ro_exp = ro_exp + 1'b1;
                ro_falls++;
            end
            if (ro_cas_n !== 1'b1) ro_cas_err++;
            ro_prev_ras = ro_ras_n;
        end
    end

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic wait_fall(input int limit);
        int base = falls;
        for (int i = 0; i < limit && falls == base; i++) step();
    endtask

    task automatic t_reset();
        step();
        chk(ras_n === 1'b1 && ro_ras_n === 1'b1, "R1 ras_n", ras_n, 1);
        chk(cas_n === 1'b1 && ro_cas_n === 1'b1, "R1 cas_n", cas_n, 1);
        chk(ref_req === 1'b0 && ro_req === 1'b0, "R1 ref_req", ref_req, 0);
        chk(mem_ready === 1'b0 && overdue === 1'b0, "R1 ready/overdue",
            {mem_ready, overdue}, 0);
        chk(we_n === 1'b1 && oe_n === 1'b1, "R1 we_n/oe_n", {we_n, oe_n}, 3);
    endtask

    task automatic t_pause();
        int n = 0;
        do begin
            step();
            n++;
        end while (!ref_req && n < PAUSE + 20);
        chk(n == PAUSE + 1, "R2 first request cycle", n, PAUSE + 1);
    endtask

    task automatic t_wake();
        int base = falls;
        for (int i = 0; i < 400 && !mem_ready; i++) step();
        chk(mem_ready === 1'b1, "R3 ready after wake-up", mem_ready, 1);
        chk(falls - base == INIT, "R3 wake-up RAS cycles", falls - base, INIT);
        chk(overdue === 1'b0, "R3 no overdue", overdue, 0);
    endtask

    task automatic t_rate();
        wait_fall(3 * INTV);
        wait_fall(3 * INTV);
        for (int k = 0; k < 4; k++) begin
            wait_fall(3 * INTV);
            chk(last_gap == INTV, "R4 refresh spacing", last_gap, INTV);
        end
    endtask

    task automatic t_strobes();
        chk(order_err == 0, "R6 CAS-before-RAS order", order_err, 0);
        chk(width_err == 0, "R6 RAS low width", width_err, 0);
        chk(prech_err == 0, "R7 precharge before release", prech_err, 0);
        chk(weoe_err == 0, "R8 we_n/oe_n inactive", weoe_err, 0);
        chk(nreq_err == 0, "R5 strobes only while requesting", nreq_err, 0);
    endtask

    task automatic t_backlog();
        int base;
        int drop = 0;
        bit seen = 0;
        wait_fall(3 * INTV);
        for (int i = 0; i < 50 && ref_req; i++) step();
        grant_en = 1'b0;
        base = falls;
        for (int i = 0; i < 2 * INTV + 5; i++) begin
            step();
            if (ref_req) seen = 1;
            else if (seen) drop++;
        end
        chk(seen, "R5 request raised while starved", seen, 1);
        chk(drop == 0, "R5 request held until grant", drop, 0);
        chk(falls == base, "R5 no RAS without grant", falls - base, 0);
        grant_en = 1'b1;
        wait_fall(50);
        wait_fall(50);
        chk(last_gap == TCSR + TRAS + TRP + 2, "R9 back-to-back catch-up",
            last_gap, TCSR + TRAS + TRP + 2);
        chk(mem_ready === 1'b1 && overdue === 1'b0, "R9 still ready",
            {mem_ready, overdue}, 2);
    endtask

    task automatic t_overdue();
        int base;
        grant_en = 1'b0;
        for (int i = 0; i < 50 && ref_gnt; i++) step();
        for (int i = 0; i < (BLOG + 3) * INTV && !overdue; i++) step();
        chk(overdue === 1'b1, "R10 overdue raised", overdue, 1);
        chk(mem_ready === 1'b0, "R10 ready withdrawn", mem_ready, 0);
        base = falls;
        grant_en = 1'b1;
        for (int i = 0; i < 400 && !mem_ready; i++) step();
        chk(falls - base == INIT, "R10 wake-up re-run", falls - base, INIT);
        chk(overdue === 1'b0 && mem_ready === 1'b1, "R10 recovered",
            {mem_ready, overdue}, 2);
    endtask

    task automatic t_rasonly();
        for (int i = 0; i < 10 * INTV; i++) step();
        chk(ro_falls >= 17, "R11 enough cycles to wrap", ro_falls, 17);
        chk(ro_addr_err == 0, "R11 row sequence", ro_addr_err, 0);
        chk(ro_cas_err == 0, "R11 cas_n held high", ro_cas_err, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_pause();
        t_wake();
        t_rate();
        t_backlog();
        t_overdue();
        t_rasonly();
        t_strobes();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 20000, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule